// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filter

This block receives asynchronous NRZ serial words on one input line and queues them for a reader. A word is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. An external strobe paces the block at 16 times the bit rate. Each bit is decided by a majority vote of three samples taken around the middle of the bit. A start bit that does not hold low at its middle is treated as noise and dropped.

Completed words go into a two-entry queue. Each entry holds the data byte, the ninth bit and a framing-error flag. The reader pops one entry per read strobe, and the three fields appear together on registered outputs. When a word finishes while the queue is full, the block sets a sticky overrun flag and discards the word. From then on no word is stored until the receive enable is dropped.

In 9-bit mode the address filter can be switched on. It then keeps only words whose ninth bit is 1, so a node can wait for its address without being woken by traffic meant for other nodes.

Top module: `addr_uart_rx`

## Requirements
- R1: After reset, `data_avail`, `overrun`, `rd_data`, `rd_bit9` and `rd_ferr` are all 0.
- R2: In 8-bit mode, a word sent with 16 strobes per bit is read back as the same byte, with bit 0 sent first, `rd_ferr` = 0 and `rd_bit9` = 0.
- R3: A level opposite to the bit, lasting one strobe near the middle of a data bit, does not change the decided value, because each bit is decided by a majority of three samples.
- R4: A low pulse on an idle line that returns high before the middle of the start bit produces no word, and the next valid word is still received correctly.
- R5: A word whose stop bit is sampled low is stored with `rd_ferr` = 1. The next word with a good stop bit reads back with `rd_ferr` = 0.
- R6: In 9-bit mode with the address filter off, every word is stored, and its ninth bit is presented on `rd_bit9` together with its byte.
- R7: The queue holds two words and returns them in arrival order. `data_avail` stays 1 until the last stored word has been read, then goes to 0.
- R8: If a word completes while two words are stored, `overrun` goes to 1 and that word is discarded. While `overrun` is 1, later words are not stored.
- R9: Driving `rx_en` low clears `overrun` on the next clock. After `rx_en` returns high, words are stored again.
- R10: With `nine_bit` = 1 and `addr_det` = 1, a word whose ninth bit is 0 is dropped, leaving `data_avail` at 0. A word whose ninth bit is 1 is stored.
- R11: A read strobe while the queue is empty leaves `rd_data`, `rd_bit9` and `rd_ferr` unchanged, and `data_avail` stays 0.
- R12: While `rx_en` is 0, activity on `rx_line` stores no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Continuous receive enable. Low resets the receive logic and clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits per word, 0 selects 8 |
| addr_det | input | 1 | In 9-bit mode, keep only words whose ninth bit is 1 |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_line | input | 1 | Serial input. Idles high |
| rd_en | input | 1 | Pop one word from the queue |
| rd_data | output | 8 | Data byte of the last popped word |
| rd_bit9 | output | 1 | Ninth bit of the last popped word |
| rd_ferr | output | 1 | Framing error of the last popped word |
| data_avail | output | 1 | At least one word is queued |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sends all 256 byte values and a spread of 9-bit values. It also forces one-strobe disturbances into the middle of data bits, where a receiver that used a single sample would flip the bit. It sends short start pulses, which a receiver without a mid-start check would turn into garbage words. A low stop bit followed by a good word shows whether the framing flag is kept per entry; a flag shared across entries would leak into the next word. Back-to-back words into a full queue, with and without a re-enable, expose a receiver that overwrites stored data or keeps storing while overrun is set. Address-filter runs catch a filter that passes data words or blocks address words.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int ARX_DW = 8;

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [ARX_DW-1:0] data;
  } arx_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} arx_state_t;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '1;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/arx_frame.sv
module arx_frame
  import arx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  logic      line,
  input  logic      nine_bit,
  output logic      done,
  output arx_word_t word
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(ARX_DW + 1);
  localparam int SMP0 = OSR / 2 - 1;
  localparam logic [CW-1:0] SMP0_C = CW'(SMP0);
  localparam logic [CW-1:0] SMP2_C = CW'(SMP0 + 2);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  arx_state_t        state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [1:0]        vsh;
  logic [ARX_DW:0]   shreg;
  logic              vote;
  logic              in_win;
  logic [BW-1:0]     last_bit;

  assign vote     = maj3({vsh, line});
  assign in_win   = (cnt >= SMP0_C) && (cnt <= SMP2_C);
  assign last_bit = nine_bit ? BW'(ARX_DW) : BW'(ARX_DW - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      vsh   <= '0;
      shreg <= '0;
      done  <= 1'b0;
      word  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (!line) begin
            state <= ST_START;
            cnt   <= CW'(1);
          end
        end else begin
          cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
          if (in_win) vsh <= {vsh[0], line};
          if (cnt == SMP2_C) begin
            case (state)
              ST_START: begin
                if (vote) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
                end
              end
              ST_DATA: shreg <= {vote, shreg[ARX_DW:1]};
              ST_STOP: begin
                done      <= 1'b1;
                word.ferr <= !vote;
                word.bit9 <= nine_bit ? shreg[ARX_DW] : 1'b0;
                word.data <= nine_bit ? shreg[ARX_DW-1:0] : shreg[ARX_DW:1];
                state     <= ST_IDLE;
                cnt       <= '0;
              end
              default: ;
            endcase
          end
          if (cnt == LAST_C) begin
            if (state == ST_START) begin
              state <= ST_DATA;
              bidx  <= '0;
            end else if (state == ST_DATA) begin
              if (bidx == last_bit) state <= ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state) == ST_STOP); // R2
endmodule

// File: rtl/arx_fifo.sv
module arx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_pop;

  assign do_pop = pop && (level != '0);
  assign full   = (level == LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      dout  <= '0;
    end else begin
      if (push)   wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_pop) begin
        rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
        dout <= mem[rptr];
      end
      case ({push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |-> !push); // R8
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> $stable(dout)); // R11
endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
  import arx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              addr_det,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              rd_en,
  output logic [ARX_DW-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              data_avail,
  output logic              overrun
);
  localparam int LVW = $clog2(FIFO_DEPTH + 1);
  localparam int WW  = $bits(arx_word_t);

  logic           line_s;
  logic           done;
  arx_word_t      word;
  arx_word_t      head;
  logic [LVW-1:0] level;
  logic           full;
  logic           accept, pop_ok, room, push, ovr_set;
  logic           overrun_q;

  arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
  );

  arx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .en(rx_en), .tick(os_tick), .line(line_s),
    .nine_bit(nine_bit), .done(done), .word(word)
  );

  assign accept  = done && !(nine_bit && addr_det && !word.bit9);
  assign pop_ok  = rd_en && (level != '0);
  assign room    = !full || pop_ok;
  assign push    = accept && !overrun_q && room;
  assign ovr_set = accept && !overrun_q && !room;

  arx_fifo #(.DEPTH(FIFO_DEPTH), .W(WW)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(word), .pop(rd_en),
    .dout(head), .level(level), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst || !rx_en) overrun_q <= 1'b0;
    else if (ovr_set)  overrun_q <= 1'b1;
  end

  assign rd_data    = head.data;
  assign rd_bit9    = head.bit9;
  assign rd_ferr    = head.ferr;
  assign data_avail = (level != '0);
  assign overrun    = overrun_q;

  AST_OVR_FREEZES_QUEUE: assert property (@(posedge clk) disable iff (rst)
    overrun |=> level <= $past(level)); // R8
  AST_DISABLE_CLEARS_OVR: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !overrun); // R9
  AST_FILTER_DROPS: assert property (@(posedge clk) disable iff (rst)
    (done && nine_bit && addr_det && !word.bit9) |=> level <= $past(level)); // R10
  AST_AVAIL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && level == LVW'(1) && !done) |=> !data_avail); // R7
endmodule

// File: tb/addr_uart_rx_tb.sv
module addr_uart_rx_tb;
  localparam int TDIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, nine_bit = 1'b0, addr_det = 1'b0;
  logic       os_tick = 1'b0, rx_line = 1'b1, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, data_avail, overrun;
  int         n_run = 0, n_fail = 0;
  int         tdiv = 0;
  int         cyc = 0;
  bit         done_flag = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == 0);
  end

  addr_uart_rx u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .nine_bit(nine_bit), .addr_det(addr_det),
    .os_tick(os_tick), .rx_line(rx_line), .rd_en(rd_en), .rd_data(rd_data),
    .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .data_avail(data_avail), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input bit g);
    rx_line = v;
    wait_ticks(8);
    if (g) rx_line = !v;
    wait_ticks(1);
    rx_line = v;
    wait_ticks(7);
  endtask

  // pos 0 = start, 1..nbits = data, nbits+1 = stop; glitch at position gpos
  task automatic send(input logic [8:0] val, input int nbits, input logic stop_v, input int gpos);
    drive_bit(1'b0, gpos == 0);
    for (int i = 0; i < nbits; i++) drive_bit(val[i], gpos == i + 1);
    drive_bit(stop_v, gpos == nbits + 1);
    rx_line = 1'b1;
    wait_ticks(20);
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    while (!done_flag && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 data_avail", data_avail, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_bit9", rd_bit9, 0);
    chk("R1 rd_ferr", rd_ferr, 0);

    // R12: disabled receiver ignores the line
    send(9'h0C3, 8, 1'b1, -1);
    chk("R12 no word while disabled", data_avail, 0);

    rx_en = 1'b1;
    wait_ticks(4);

    // R2: sweep all bytes
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 8, 1'b1, -1);
      chk("R2 avail", data_avail, 1);
      rd();
      chk("R2 data", rd_data, v);
      chk("R2 ferr", rd_ferr, 0);
      chk("R2 bit9", rd_bit9, 0);
    end

    // R3: one-strobe disturbance in each data bit
    for (int b = 1; b <= 8; b++) begin
      send(9'h05A ^ 9'(b * 37), 8, 1'b1, b);
      rd();
      chk("R3 majority", rd_data, (8'h5A ^ 8'(b * 37)));
    end

    // R4: short start pulse
    rx_line = 1'b0;
    wait_ticks(4);
    rx_line = 1'b1;
    wait_ticks(32);
    chk("R4 no word from glitch", data_avail, 0);
    send(9'h03C, 8, 1'b1, -1);
    rd();
    chk("R4 recovery", rd_data, 8'h3C);

    // R5: framing error travels with its word
    send(9'h0A5, 8, 1'b0, -1);
    send(9'h017, 8, 1'b1, -1);
    rd();
    chk("R5 ferr set", rd_ferr, 1);
    chk("R5 ferr data", rd_data, 8'hA5);
    rd();
    chk("R5 ferr next clear", rd_ferr, 0);
    chk("R5 next data", rd_data, 8'h17);

    // R11: empty read leaves outputs unchanged
    rd();
    chk("R11 data kept", rd_data, 8'h17);
    chk("R11 ferr kept", rd_ferr, 0);
    chk("R11 avail", data_avail, 0);

    // R7/R8: fill, overrun, order
    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b1, -1);
    chk("R7 avail two", data_avail, 1);
    chk("R8 no overrun yet", overrun, 0);
    send(9'h033, 8, 1'b1, -1);
    chk("R8 overrun set", overrun, 1);
    rd();
    chk("R7 first", rd_data, 8'h11);
    chk("R7 still avail", data_avail, 1);
    rd();
    chk("R7 second", rd_data, 8'h22);
    chk("R7 avail clear", data_avail, 0);
    send(9'h044, 8, 1'b1, -1);
    chk("R8 blocked while overrun", data_avail, 0);
    chk("R8 overrun sticky", overrun, 1);

    // R9: toggle enable
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R9 overrun cleared", overrun, 0);
    rx_en = 1'b1;
    send(9'h055, 8, 1'b1, -1);
    rd();
    chk("R9 resumed", rd_data, 8'h55);

    // R6: 9-bit, filter off
    nine_bit = 1'b1;
    for (int i = 0; i < 32; i++) begin
      send(9'((i * 83 + 5) % 512), 9, 1'b1, -1);
      rd();
      chk("R6 data", rd_data, ((i * 83 + 5) % 512) & 255);
      chk("R6 bit9", rd_bit9, ((i * 83 + 5) % 512) >> 8);
    end

    // R10: address filter
    addr_det = 1'b1;
    send(9'h0A7, 9, 1'b1, -1);
    chk("R10 data word dropped", data_avail, 0);
    send(9'h15A, 9, 1'b1, -1);
    chk("R10 address kept", data_avail, 1);
    rd();
    chk("R10 addr data", rd_data, 8'h5A);
    chk("R10 addr bit9", rd_bit9, 1);
    addr_det = 1'b0;
    send(9'h0A7, 9, 1'b1, -1);
    rd();
    chk("R10 filter off accepts", rd_data, 8'hA7);
    chk("R10 filter off bit9", rd_bit9, 0);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule